// File: doc/BRIEF.md
# Coprocessor Compare Flag Generator

This block compares two operands taken from a bank of sixteen 64-bit registers and produces a 32-bit status word. The host core copies that word into its condition flags. The four flags sit in the top nibble of the word and every other bit is zero. Four compare kinds are supported: signed 32-bit integer, 64-bit integer, single-precision float and double-precision float.

The register bank lives outside the block. The block drives the two register indices out on its read-address ports and expects the bank to return both 64-bit words combinationally in the same cycle. A request is a one-cycle strobe that comes with a group select and a 3-bit sub-opcode. One clock later the flag word is updated and a one-cycle valid pulse is raised. The word then holds its value until the next accepted request. NaN operands are not given any special treatment. The block never writes the register bank.

Top module: `cmpflag_unit`

## Requirements
- R1: The flag word carries N in bit 31, Z in bit 30, C in bit 29 and V in bit 28. Bits 27 down to 0 are always zero.
- R2: A 32-bit integer compare works only on bits 31:0 of each register and forms the difference first minus second. Z is set when that difference is zero. N is set when its top bit is one.
- R3: For both integer kinds, C is set when the subtraction produces no borrow, that is, when the first operand is at least the second taken as unsigned numbers.
- R4: For both integer kinds, V is set when the signed subtraction overflows. This happens when the operand signs differ and the sign of the result differs from the sign of the first operand.
- R5: A 64-bit integer compare uses the full register and the same N, Z, C and V rules at 64-bit width.
- R6: For both float kinds, Z means equal, N means first less than second, C means first greater than second, and V is zero. Exactly one of N, Z and C is set.
- R7: Single precision takes bits 63:32 of each register. Double precision takes all 64 bits.
- R8: Positive zero and negative zero compare equal in both float kinds.
- R9: The group select is 0 for float and 1 for integer. Sub-opcode 4 picks single precision or 32-bit integer. Sub-opcode 5 picks double precision or 64-bit integer. Any other sub-opcode is ignored: no valid pulse is raised and the word does not change.
- R10: An accepted request sampled at a rising edge raises the valid output for exactly the following cycle, with the new word present. Requests on back-to-back cycles each produce their own result. The word holds whenever valid is low.
- R11: Synchronous reset clears the flag word and the valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqStrobe | input | 1 | Compare request, one cycle per compare |
| isIntGroup | input | 1 | 0 = float group, 1 = integer group |
| subOp | input | 3 | Compare sub-opcode (4 narrow, 5 wide) |
| idxA | input | 4 | Index of the first operand register |
| idxB | input | 4 | Index of the second operand register |
| rdIdxA | output | 4 | Read address to the bank for the first operand |
| rdIdxB | output | 4 | Read address to the bank for the second operand |
| rdDataA | input | 64 | Bank read data for the first operand |
| rdDataB | input | 64 | Bank read data for the second operand |
| flagWord | output | 32 | Status word, flags in bits 31:28 |
| resValid | output | 1 | One-cycle pulse marking a fresh flag word |

## Verification
The only state in the block is the valid bit and the registered word. A fault in either one shows up at the ports in the cycle right after the request that caused it. A wrongly decoded kind shows up as the wrong nibble in the sampled word. A missing or stretched pulse shows up as a valid level that breaks the one-cycle rule. A word that drifts while valid is low shows up at the next idle-cycle sample. The stimulus is chosen so that each kind produces results that differ from the other kinds: upper halves disagree while lower halves agree, signed order disagrees with unsigned order, and the two zeros are compared against each other. Because of this, a wrong half, width or ordering produces a wrong flag value rather than the same one.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

  typedef enum logic [1:0] {
    KIND_INT_NARROW = 2'd0,
    KIND_INT_WIDE   = 2'd1,
    KIND_FP_NARROW  = 2'd2,
    KIND_FP_WIDE    = 2'd3
  } cmpKind_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     load;
    cmpKind_t kind;
  } cmpCtrl_t;

  localparam int SUBOP_W       = 3;
  localparam logic [SUBOP_W-1:0] SUBOP_NARROW = 3'd4;
  localparam logic [SUBOP_W-1:0] SUBOP_WIDE   = 3'd5;
  localparam int NZCV_W        = 4;

endpackage

// File: rtl/cmpflag_ctrl.sv
module cmpflag_ctrl
  import cmpflag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reqStrobe,
  input  logic               isIntGroup,
  input  logic [SUBOP_W-1:0] subOp,
  output cmpCtrl_t           ctrl,
  output logic               resValid
);

  logic isNarrow;
  logic isWide;
  logic accept;
  logic validQ;

  assign isNarrow = (subOp == SUBOP_NARROW);
  assign isWide   = (subOp == SUBOP_WIDE);
  assign accept   = reqStrobe && (isNarrow || isWide);

  always_comb begin
    ctrl.load = accept;
    unique case ({isIntGroup, isWide})
      2'b10:   ctrl.kind = KIND_INT_NARROW;
      2'b11:   ctrl.kind = KIND_INT_WIDE;
      2'b00:   ctrl.kind = KIND_FP_NARROW;
      default: ctrl.kind = KIND_FP_WIDE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= accept;
  end

  assign resValid = validQ;

endmodule

// File: rtl/cmpflag_icmp.sv
// Integer subtract-compare at width W, producing N, Z, C, V.
module cmpflag_icmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         flagN,
  output logic         flagZ,
  output logic         flagC,
  output logic         flagV
);

  logic [W:0]   extSum;
  logic [W-1:0] diff;

  // a - b as a + ~b + 1; bit W is the no-borrow carry.
  assign extSum = {1'b0, opA} + {1'b0, ~opB} + {{W{1'b0}}, 1'b1};
  assign diff   = extSum[W-1:0];

  assign flagN = diff[W-1];
  assign flagZ = (diff == '0);
  assign flagC = extSum[W];
  assign flagV = (opA[W-1] ^ opB[W-1]) & (diff[W-1] ^ opA[W-1]);

endmodule

// File: rtl/cmpflag_fcmp.sv
// Ordered IEEE-style compare at width W (sign bit at top); NaN not special.
module cmpflag_fcmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         isLess,
  output logic         isEqual,
  output logic         isGreater
);

  logic [W-1:0] keyA;
  logic [W-1:0] keyB;
  logic         bothZero;

  // Map sign-magnitude to an unsigned ordering key.
  assign keyA = opA[W-1] ? ~opA : {1'b1, opA[W-2:0]};
  assign keyB = opB[W-1] ? ~opB : {1'b1, opB[W-2:0]};

  assign bothZero  = (opA[W-2:0] == '0) && (opB[W-2:0] == '0);
  assign isEqual   = bothZero || (opA == opB);
  assign isLess    = !isEqual && (keyA < keyB);
  assign isGreater = !isEqual && !isLess;

endmodule

// File: rtl/cmpflag_datapath.sv
module cmpflag_datapath
  import cmpflag_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  cmpCtrl_t          ctrl,
  input  logic [REG_W-1:0]  opA,
  input  logic [REG_W-1:0]  opB,
  output logic [WORD_W-1:0] flagWord
);

  localparam int HALF_W = REG_W / 2;
  localparam int PAD_W  = WORD_W - NZCV_W;

  // Per-kind flag nibbles, {N,Z,C,V}.
  logic [NZCV_W-1:0] kindFlags [4];
  logic [NZCV_W-1:0] selFlags;
  logic [WORD_W-1:0] wordQ;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_int
      localparam int IW = (gi == 0) ? HALF_W : REG_W;
      logic n, z, c, v;
      cmpflag_icmp #(.W(IW)) u_icmp (
        .opA   (opA[IW-1:0]),
        .opB   (opB[IW-1:0]),
        .flagN (n),
        .flagZ (z),
        .flagC (c),
        .flagV (v)
      );
      assign kindFlags[gi] = {n, z, c, v};
    end

    for (gi = 0; gi < 2; gi++) begin : g_fp
      localparam int FW = (gi == 0) ? HALF_W : REG_W;
      logic lt, eq, gt;
      cmpflag_fcmp #(.W(FW)) u_fcmp (
        .opA       (opA[REG_W-1 -: FW]),
        .opB       (opB[REG_W-1 -: FW]),
        .isLess    (lt),
        .isEqual   (eq),
        .isGreater (gt)
      );
      assign kindFlags[2 + gi] = {lt, eq, gt, 1'b0};
    end
  endgenerate

  assign selFlags = kindFlags[ctrl.kind];

  always_ff @(posedge clk) begin
    if (rst)            wordQ <= '0;
    else if (ctrl.load) wordQ <= {selFlags, {PAD_W{1'b0}}};
  end

  assign flagWord = wordQ;

endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpflag_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int REG_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqStrobe,
  input  logic               isIntGroup,
  input  logic [SUBOP_W-1:0] subOp,
  input  logic [IDX_W-1:0]   idxA,
  input  logic [IDX_W-1:0]   idxB,
  output logic [IDX_W-1:0]   rdIdxA,
  output logic [IDX_W-1:0]   rdIdxB,
  input  logic [REG_W-1:0]   rdDataA,
  input  logic [REG_W-1:0]   rdDataB,
  output logic [WORD_W-1:0]  flagWord,
  output logic               resValid
);

  cmpCtrl_t ctrl;

  assign rdIdxA = idxA;
  assign rdIdxB = idxB;

  cmpflag_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqStrobe  (reqStrobe),
    .isIntGroup (isIntGroup),
    .subOp      (subOp),
    .ctrl       (ctrl),
    .resValid   (resValid)
  );

  cmpflag_datapath #(.REG_W(REG_W), .WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opA      (rdDataA),
    .opB      (rdDataB),
    .flagWord (flagWord)
  );

endmodule

// File: rtl/cmpflag_checker.sv
module cmpflag_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reqStrobe,
  input logic              isIntGroup,
  input logic [2:0]        subOp,
  input logic [WORD_W-1:0] flagWord,
  input logic              resValid
);

  logic goodCode;
  assign goodCode = (subOp == 3'd4) || (subOp == 3'd5);

  // R10: accepted request gives valid next cycle
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (reqStrobe && goodCode) |=> resValid);

  // R9: unsupported code raises no valid
  a_r9_bad_code_silent: assert property (@(posedge clk) disable iff (rst)
    (reqStrobe && !goodCode) |=> !resValid);

  // R10: word holds while valid is low
  a_r10_word_holds: assert property (@(posedge clk) disable iff (rst)
    !resValid |-> $stable(flagWord));

  // R6: float result sets exactly one of N, Z, C and clears V
  a_r6_float_onehot: assert property (@(posedge clk) disable iff (rst)
    (resValid && !$past(isIntGroup)) |->
      ($countones(flagWord[31:29]) == 1 && !flagWord[28]));

  // R3: integer equality implies no borrow
  a_r3_zero_implies_carry: assert property (@(posedge clk) disable iff (rst)
    (resValid && $past(isIntGroup) && flagWord[30]) |-> flagWord[29]);

  // R2: zero and negative never together
  a_r2_zn_exclusive: assert property (@(posedge clk) disable iff (rst)
    resValid |-> !(flagWord[31] && flagWord[30]));

endmodule

bind cmpflag_unit cmpflag_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reqStrobe  (reqStrobe),
  .isIntGroup (isIntGroup),
  .subOp      (subOp),
  .flagWord   (flagWord),
  .resValid   (resValid)
);

// File: tb/cmpflag_unit_test.sv
module cmpflag_unit_test;

  typedef struct packed {
    logic        isInt;
    logic [2:0]  sub;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  nzcv;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd4, 64'h0000000000000005, 64'h0000000000000003, 4'h2}, // R2 R3
    '{1'b1, 3'd4, 64'h0000000000000003, 64'h0000000000000005, 4'h8}, // R2
    '{1'b1, 3'd4, 64'h0000000000000007, 64'h0000000000000007, 4'h6}, // R2 R3
    '{1'b1, 3'd4, 64'h0000000080000000, 64'h0000000000000001, 4'h3}, // R4
    '{1'b1, 3'd4, 64'h000000007FFFFFFF, 64'h00000000FFFFFFFF, 4'h9}, // R4
    '{1'b1, 3'd4, 64'hDEAD000000000004, 64'h1234000000000004, 4'h6}, // R2 low half
    '{1'b1, 3'd5, 64'h0000000100000000, 64'h00000000FFFFFFFF, 4'h2}, // R5
    '{1'b1, 3'd5, 64'h8000000000000000, 64'h0000000000000001, 4'h3}, // R5
    '{1'b1, 3'd5, 64'h0000000000000000, 64'h0000000000000001, 4'h8}, // R5
    '{1'b0, 3'd4, 64'h3F80000000000009, 64'h4000000000000001, 4'h8}, // R6 R7
    '{1'b0, 3'd4, 64'h400000000000000F, 64'h3F80000000000000, 4'h2}, // R6
    '{1'b0, 3'd4, 64'h0000000012345678, 64'h8000000000000000, 4'h4}, // R8
    '{1'b0, 3'd4, 64'hBF80000000000000, 64'hC000000000000000, 4'h2}, // R6
    '{1'b0, 3'd4, 64'h3F80000000000001, 64'h3F80000000000002, 4'h4}, // R7
    '{1'b0, 3'd5, 64'h3FF0000000000000, 64'hBFF0000000000000, 4'h2}, // R6
    '{1'b0, 3'd5, 64'h400921FB54442D18, 64'h400921FB54442D18, 4'h4}, // R6
    '{1'b0, 3'd5, 64'hC008000000000000, 64'h4004000000000000, 4'h8}, // R7
    '{1'b0, 3'd5, 64'h0000000000000000, 64'h8000000000000000, 4'h4}  // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqStrobe = 1'b0;
  logic        isIntGroup = 1'b0;
  logic [2:0]  subOp = 3'd0;
  logic [3:0]  idxA = 4'd0;
  logic [3:0]  idxB = 4'd0;
  logic [3:0]  rdIdxA, rdIdxB;
  logic [63:0] rdDataA, rdDataB;
  logic [31:0] flagWord;
  logic        resValid;
  logic [63:0] bank [16];

  int nChecks = 0;
  int nFails  = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  assign rdDataA = bank[rdIdxA];
  assign rdDataB = bank[rdIdxB];

  cmpflag_unit uut (
    .clk(clk), .rst(rst), .reqStrobe(reqStrobe), .isIntGroup(isIntGroup),
    .subOp(subOp), .idxA(idxA), .idxB(idxB), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .flagWord(flagWord), .resValid(resValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a negedge; return at the negedge after the edge that loads it.
  task automatic request(input logic grp, input logic [2:0] sop,
                         input logic [3:0] ia, input logic [3:0] ib);
    @(negedge clk);
    isIntGroup = grp; subOp = sop; idxA = ia; idxB = ib; reqStrobe = 1'b1;
    @(negedge clk);
    reqStrobe = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bank[i] = 64'h0;
    repeat (3) @(negedge clk);
    check("R11 reset word", flagWord, 32'h0);
    check("R11 reset valid", {31'b0, resValid}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bank[1] = VECS[i].a;
      bank[2] = VECS[i].b;
      request(VECS[i].isInt, VECS[i].sub, 4'd1, 4'd2);
      check($sformatf("R1 R10 vec%0d valid", i), {31'b0, resValid}, 32'h1);
      check($sformatf("R1 vec%0d word", i), flagWord, {VECS[i].nzcv, 28'h0});
      @(negedge clk);
      check($sformatf("R10 vec%0d pulse ends", i), {31'b0, resValid}, 32'h0);
      check($sformatf("R10 vec%0d word holds", i), flagWord, {VECS[i].nzcv, 28'h0});
    end

    // R9: unsupported sub-opcodes leave word and valid alone (word is 0x4 nibble now)
    bank[3] = 64'h0000000000000001;
    bank[4] = 64'h0000000000000009;
    for (int c = 0; c < 8; c++) begin
      if (c == 4 || c == 5) continue;
      request(1'b1, 3'(c), 4'd3, 4'd4);
      check($sformatf("R9 code%0d no valid", c), {31'b0, resValid}, 32'h0);
      check($sformatf("R9 code%0d word kept", c), flagWord, 32'h4000_0000);
    end

    // R2: same register on both sides is equal
    request(1'b1, 3'd4, 4'd4, 4'd4);
    check("R2 self compare", flagWord, 32'h6000_0000);

    // R10: back-to-back requests each get a result
    @(negedge clk);
    isIntGroup = 1'b1; subOp = 3'd4; idxA = 4'd3; idxB = 4'd4; reqStrobe = 1'b1;
    @(negedge clk);
    check("R10 b2b first valid", {31'b0, resValid}, 32'h1);
    check("R10 b2b first word", flagWord, 32'h8000_0000);
    idxA = 4'd4; idxB = 4'd3;
    @(negedge clk);
    reqStrobe = 1'b0;
    check("R10 b2b second valid", {31'b0, resValid}, 32'h1);
    check("R10 b2b second word", flagWord, 32'h2000_0000);
    @(negedge clk);
    check("R10 b2b idle", {31'b0, resValid}, 32'h0);

    // R11: reset mid-run clears a nonzero word
    rst = 1'b1;
    @(negedge clk);
    check("R11 mid reset word", flagWord, 32'h0);
    check("R11 mid reset valid", {31'b0, resValid}, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule